// File: doc/BRIEF.md
# Processor Exception Entry and Return Controller

This block owns the exception-related control state of a 32-bit processor core. When the pipeline reports a fault, it supplies the exception number, the address of the faulting instruction and a flag that says whether that instruction sits in a branch delay slot. The controller works out the address at which execution should resume once the handler is done, and stores it in the saved-PC register. It copies the live status register into the saved-status register and records the delay-slot flag in the status register. One cycle later it emits a fetch redirect to the handler. A breakpoint trap does not vector: it raises a one-cycle halt pulse that carries the trap address, for a debug unit to pick up.

A return-from-exception request restores the status register from its saved copy, with the fixed-one bit forced high, and redirects fetch to the saved PC. Every redirect, whether on entry or on return, comes with a pulse that tells the front end to drop any pending delay-slot state. An exception number outside the supported set raises a one-cycle error pulse and changes nothing else. A simple write port lets system software load any of the three registers.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status register reads 0x00008001, the saved-status and saved-PC registers read 0, and the redirect, halt, error and delay-slot-clear outputs are all low.
- R2: Floating-point (number 13) and system-call (number 12) exceptions save PC+4, or the faulting PC itself when the delay-slot flag is set.
- R3: Bus-error (2), alignment (6), illegal-instruction (7) and range (11) exceptions save the faulting PC, or the faulting PC minus 4 when the delay-slot flag is set.
- R4: On entry the saved-status register takes the status value from before the entry, and status bit 13 takes the delay-slot flag; all other status bits keep their values.
- R5: The handler address is the exception number shifted left by 8, plus 0xF0000000 when status bit 14 (the handler-prefix bit) was set before the entry, and plus 0 otherwise.
- R6: A reset-class exception (number 1) vectors and updates the saved-status register and status bit 13, but leaves the saved-PC register unchanged.
- R7: A trap (number 14) produces a halt pulse that carries the request PC, and no redirect. It leaves all three registers unchanged.
- R8: A return request loads status from the saved-status register with bit 15 forced to 1, and redirects to the saved-PC value.
- R9: The redirect, halt and error outputs are registered. Each is high for exactly the one cycle after the request that causes it. The delay-slot-clear output pulses with every redirect, on entry and on return. Requests on consecutive cycles give consecutive pulses.
- R10: An exception number outside {1,2,6,7,11,12,13,14} pulses the error output, produces no redirect and no halt, and changes no register.
- R11: An exception request takes priority over a return request in the same cycle, and the return is dropped. A software write is dropped in any cycle with an exception or return request. Software writes use select 0 for status, 1 for saved status, 2 for saved PC and 3 for no register, and take effect on the next cycle.
- R12: A software write to the status register always sets bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Exception request |
| exc_num_i | input | VEC_W | Exception number |
| exc_pc_i | input | XLEN | Address of the faulting instruction |
| exc_dslot_i | input | 1 | Faulting instruction sits in a delay slot |
| ret_valid_i | input | 1 | Return-from-exception request |
| reg_we_i | input | 1 | Software register write enable |
| reg_sel_i | input | 2 | Register select: 0 status, 1 saved status, 2 saved PC, 3 none |
| reg_wdata_i | input | XLEN | Software write data |
| sr_o | output | XLEN | Status register |
| esr_o | output | XLEN | Saved-status register |
| epcr_o | output | XLEN | Saved-PC register |
| redir_o | output | 1 | Fetch redirect strobe |
| redir_pc_o | output | XLEN | Redirect target |
| halt_o | output | 1 | Trap halt strobe |
| halt_pc_o | output | XLEN | Address of the trap |
| bad_num_o | output | 1 | Unsupported exception number strobe |
| dslot_clr_o | output | 1 | Clear pending delay-slot state |

## Verification
The hardest case to reach is a collision: an exception request, a return request and a software write all land in the same cycle. Only one of the three may take effect, and its effect shows up only a cycle later. The bench drives all three in one cycle. It then reads back the registers and the single redirect it expects. Another hard case is the delay-slot correction combined with the handler prefix. The bench reaches it by first loading bit 14 of the status register through the write port, then raising a delay-slot alignment fault. It also sends requests back to back, so that adjacent pulses have to stay separate.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EC_NONE,
    EC_RESET,
    EC_AT_PC,
    EC_NEXT_PC,
    EC_TRAP,
    EC_BAD
  } exc_class_e;

  localparam int unsigned SR_FO_BIT  = 15;
  localparam int unsigned SR_EPH_BIT = 14;
  localparam int unsigned SR_DSX_BIT = 13;

  localparam int unsigned NUM_RESET   = 1;
  localparam int unsigned NUM_BUSERR  = 2;
  localparam int unsigned NUM_ALIGN   = 6;
  localparam int unsigned NUM_ILLEGAL = 7;
  localparam int unsigned NUM_RANGE   = 11;
  localparam int unsigned NUM_SYSCALL = 12;
  localparam int unsigned NUM_FPE     = 13;
  localparam int unsigned NUM_TRAP    = 14;

  localparam logic [1:0] SEL_SR   = 2'd0;
  localparam logic [1:0] SEL_ESR  = 2'd1;
  localparam logic [1:0] SEL_EPCR = 2'd2;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int unsigned VEC_W = 5
) (
  input  logic             valid_i,
  input  logic [VEC_W-1:0] num_i,
  output exc_class_e       cls_o
);

  function automatic exc_class_e classify(input logic [VEC_W-1:0] n);
    exc_class_e c;
    case (int'(n))
      NUM_RESET:                                   c = EC_RESET;
      NUM_BUSERR, NUM_ALIGN, NUM_ILLEGAL, NUM_RANGE: c = EC_AT_PC;
      NUM_SYSCALL, NUM_FPE:                        c = EC_NEXT_PC;
      NUM_TRAP:                                    c = EC_TRAP;
      default:                                     c = EC_BAD;
    endcase
    return c;
  endfunction

  assign cls_o = valid_i ? classify(num_i) : EC_NONE;

endmodule

// File: rtl/exc_pc_calc.sv
module exc_pc_calc
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     VEC_W       = 5,
  parameter int unsigned     VEC_SHIFT   = 8,
  parameter int unsigned     INSN_BYTES  = 4,
  parameter logic [XLEN-1:0] PREFIX_BASE = 32'hF000_0000
) (
  input  exc_class_e       cls_i,
  input  logic [VEC_W-1:0] num_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             dslot_i,
  input  logic             prefix_i,
  output logic [XLEN-1:0]  saved_pc_o,
  output logic             save_pc_o,
  output logic [XLEN-1:0]  handler_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  // Resume address: one instruction past the fault for the "after" class,
  // the fault itself otherwise; a delay slot steps back to the branch.
  function automatic logic [XLEN-1:0] resume_pc(input exc_class_e c,
                                                input logic [XLEN-1:0] pc,
                                                input logic ds);
    logic [XLEN-1:0] base;
    base = (c == EC_NEXT_PC) ? pc + STEP : pc;
    return ds ? base - STEP : base;
  endfunction

  function automatic logic [XLEN-1:0] vector_addr(input logic [VEC_W-1:0] n,
                                                  input logic pre);
    logic [XLEN-1:0] base;
    base = pre ? PREFIX_BASE : '0;
    return base + (XLEN'(n) << VEC_SHIFT);
  endfunction

  assign saved_pc_o = resume_pc(cls_i, pc_i, dslot_i);
  assign save_pc_o  = (cls_i == EC_AT_PC) || (cls_i == EC_NEXT_PC);
  assign handler_o  = vector_addr(num_i, prefix_i);

endmodule

// File: rtl/exc_arch_regs.sv
module exc_arch_regs
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] SR_RESET = 32'h0000_8001
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            entry_i,
  input  logic            ret_i,
  input  logic            hold_sw_i,
  input  logic            dslot_i,
  input  logic            save_pc_i,
  input  logic [XLEN-1:0] saved_pc_i,
  input  logic            sw_we_i,
  input  logic [1:0]      sw_sel_i,
  input  logic [XLEN-1:0] sw_wdata_i,
  output logic [XLEN-1:0] sr_o,
  output logic [XLEN-1:0] esr_o,
  output logic [XLEN-1:0] epcr_o
);

  localparam logic [XLEN-1:0] FO_MASK = XLEN'(1) << SR_FO_BIT;

  logic [XLEN-1:0] sr_q, esr_q, epcr_q;
  logic [XLEN-1:0] sr_d, esr_d, epcr_d;
  logic            sw_live;

  assign sw_live = sw_we_i && !hold_sw_i;

  always_comb begin
    sr_d   = sr_q;
    esr_d  = esr_q;
    epcr_d = epcr_q;
    if (entry_i) begin
      esr_d            = sr_q;
      sr_d[SR_DSX_BIT] = dslot_i;
      if (save_pc_i) epcr_d = saved_pc_i;
    end else if (ret_i) begin
      sr_d = esr_q | FO_MASK;
    end else if (sw_live) begin
      case (sw_sel_i)
        SEL_SR:   sr_d   = sw_wdata_i | FO_MASK;
        SEL_ESR:  esr_d  = sw_wdata_i;
        SEL_EPCR: epcr_d = sw_wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sr_q   <= SR_RESET;
      esr_q  <= '0;
      epcr_q <= '0;
    end else begin
      sr_q   <= sr_d;
      esr_q  <= esr_d;
      epcr_q <= epcr_d;
    end
  end

  assign sr_o   = sr_q;
  assign esr_o  = esr_q;
  assign epcr_o = epcr_q;

  // R4: saved status takes the pre-entry status
  a_r4_esr_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i |=> esr_q == $past(sr_q));
  // R4: delay-slot flag lands in the status register
  a_r4_dsx_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i |=> sr_q[SR_DSX_BIT] == $past(dslot_i));
  // R6: reset-class entry keeps the saved PC
  a_r6_keep_epcr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_i && !save_pc_i) |=> $stable(epcr_q));
  // R8: return always leaves the fixed-one bit set
  a_r8_ret_fo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !entry_i) |=> sr_q[SR_FO_BIT]);
  // R12: software status writes keep the fixed-one bit set
  a_r12_sw_fo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_live && sw_sel_i == SEL_SR) |=> sr_q[SR_FO_BIT]);

endmodule

// File: rtl/exc_event_out.sv
module exc_event_out #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            entry_i,
  input  logic            ret_i,
  input  logic            trap_i,
  input  logic            bad_i,
  input  logic [XLEN-1:0] handler_i,
  input  logic [XLEN-1:0] ret_pc_i,
  input  logic [XLEN-1:0] trap_pc_i,
  output logic            redir_o,
  output logic [XLEN-1:0] redir_pc_o,
  output logic            halt_o,
  output logic [XLEN-1:0] halt_pc_o,
  output logic            bad_o,
  output logic            dslot_clr_o
);

  logic            redir_q, halt_q, bad_q;
  logic [XLEN-1:0] redir_pc_q, halt_pc_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      redir_q    <= 1'b0;
      halt_q     <= 1'b0;
      bad_q      <= 1'b0;
      redir_pc_q <= '0;
      halt_pc_q  <= '0;
    end else begin
      redir_q <= entry_i || ret_i;
      halt_q  <= trap_i;
      bad_q   <= bad_i;
      if (entry_i)    redir_pc_q <= handler_i;
      else if (ret_i) redir_pc_q <= ret_pc_i;
      if (trap_i)     halt_pc_q  <= trap_pc_i;
    end
  end

  assign redir_o     = redir_q;
  assign redir_pc_o  = redir_pc_q;
  assign halt_o      = halt_q;
  assign halt_pc_o   = halt_pc_q;
  assign bad_o       = bad_q;
  assign dslot_clr_o = redir_q;

  // R9: a redirect follows its cause by exactly one cycle
  a_r9_redir_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_i || ret_i) |=> redir_o);
  // R9: no redirect without a cause
  a_r9_redir_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(entry_i || ret_i) |=> !redir_o);
  // R7: a trap halts instead of redirecting
  a_r7_halt_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> halt_o && !redir_o && halt_pc_o == $past(trap_pc_i));
  // R10: bad number raises only the error strobe
  a_r10_bad_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i |=> bad_o && !redir_o && !halt_o);

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN        = 32,
  parameter int unsigned     VEC_W       = 5,
  parameter int unsigned     VEC_SHIFT   = 8,
  parameter int unsigned     INSN_BYTES  = 4,
  parameter logic [XLEN-1:0] PREFIX_BASE = 32'hF000_0000,
  parameter logic [XLEN-1:0] SR_RESET    = 32'h0000_8001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_valid_i,
  input  logic [VEC_W-1:0] exc_num_i,
  input  logic [XLEN-1:0]  exc_pc_i,
  input  logic             exc_dslot_i,
  input  logic             ret_valid_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [XLEN-1:0]  reg_wdata_i,
  output logic [XLEN-1:0]  sr_o,
  output logic [XLEN-1:0]  esr_o,
  output logic [XLEN-1:0]  epcr_o,
  output logic             redir_o,
  output logic [XLEN-1:0]  redir_pc_o,
  output logic             halt_o,
  output logic [XLEN-1:0]  halt_pc_o,
  output logic             bad_num_o,
  output logic             dslot_clr_o
);

  exc_class_e      cls;
  logic [XLEN-1:0] saved_pc, handler;
  logic            save_pc;
  logic [XLEN-1:0] sr_q, esr_q, epcr_q;

  // named internal events
  logic entry_evt, ret_evt, trap_evt, bad_evt, hold_sw;

  exc_classify #(.VEC_W(VEC_W)) u_cls (
    .valid_i (exc_valid_i),
    .num_i   (exc_num_i),
    .cls_o   (cls)
  );

  assign entry_evt = (cls == EC_RESET) || (cls == EC_AT_PC) || (cls == EC_NEXT_PC);
  assign trap_evt  = (cls == EC_TRAP);
  assign bad_evt   = (cls == EC_BAD);
  assign ret_evt   = ret_valid_i && !exc_valid_i;
  assign hold_sw   = exc_valid_i || ret_valid_i;

  exc_pc_calc #(
    .XLEN(XLEN), .VEC_W(VEC_W), .VEC_SHIFT(VEC_SHIFT),
    .INSN_BYTES(INSN_BYTES), .PREFIX_BASE(PREFIX_BASE)
  ) u_pc (
    .cls_i      (cls),
    .num_i      (exc_num_i),
    .pc_i       (exc_pc_i),
    .dslot_i    (exc_dslot_i),
    .prefix_i   (sr_q[SR_EPH_BIT]),
    .saved_pc_o (saved_pc),
    .save_pc_o  (save_pc),
    .handler_o  (handler)
  );

  exc_arch_regs #(.XLEN(XLEN), .SR_RESET(SR_RESET)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .entry_i    (entry_evt),
    .ret_i      (ret_evt),
    .hold_sw_i  (hold_sw),
    .dslot_i    (exc_dslot_i),
    .save_pc_i  (save_pc),
    .saved_pc_i (saved_pc),
    .sw_we_i    (reg_we_i),
    .sw_sel_i   (reg_sel_i),
    .sw_wdata_i (reg_wdata_i),
    .sr_o       (sr_q),
    .esr_o      (esr_q),
    .epcr_o     (epcr_q)
  );

  exc_event_out #(.XLEN(XLEN)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .entry_i     (entry_evt),
    .ret_i       (ret_evt),
    .trap_i      (trap_evt),
    .bad_i       (bad_evt),
    .handler_i   (handler),
    .ret_pc_i    (epcr_q),
    .trap_pc_i   (exc_pc_i),
    .redir_o     (redir_o),
    .redir_pc_o  (redir_pc_o),
    .halt_o      (halt_o),
    .halt_pc_o   (halt_pc_o),
    .bad_o       (bad_num_o),
    .dslot_clr_o (dslot_clr_o)
  );

  assign sr_o   = sr_q;
  assign esr_o  = esr_q;
  assign epcr_o = epcr_q;

  // R10: an unsupported number leaves every register untouched
  a_r10_bad_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_evt |=> $stable(sr_o) && $stable(esr_o) && $stable(epcr_o));
  // R7: a trap leaves every register untouched
  a_r7_trap_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_evt |=> $stable(sr_o) && $stable(esr_o) && $stable(epcr_o));
  // R11: a return loses to an exception in the same cycle
  a_r11_exc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && ret_valid_i && cls == EC_TRAP) |=> !redir_o);
  // R9: event strobes are mutually exclusive
  a_r9_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({redir_o, halt_o, bad_num_o}));

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0, exc_dslot = 1'b0, ret_valid = 1'b0, reg_we = 1'b0;
  logic [4:0]  exc_num = '0;
  logic [31:0] exc_pc = '0, reg_wdata = '0;
  logic [1:0]  reg_sel = 2'd3;
  logic [31:0] sr, esr, epcr, redir_pc, halt_pc;
  logic        redir, halt, bad_num, dslot_clr;

  always #10 clk = ~clk;  // 50 MHz

  exc_entry_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .exc_valid_i(exc_valid), .exc_num_i(exc_num), .exc_pc_i(exc_pc),
    .exc_dslot_i(exc_dslot), .ret_valid_i(ret_valid),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .sr_o(sr), .esr_o(esr), .epcr_o(epcr),
    .redir_o(redir), .redir_pc_o(redir_pc), .halt_o(halt), .halt_pc_o(halt_pc),
    .bad_num_o(bad_num), .dslot_clr_o(dslot_clr)
  );

  typedef struct {
    logic        redir;
    logic        halt;
    logic        err;
    logic [31:0] pc;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [31:0] m_sr = 32'h0000_8001, m_esr = '0, m_epcr = '0;

  // monitor: sample a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && !done) begin
        exp_t        e;
        logic [31:0] got_pc;
        bit          popped;
        popped = sb_q.size() > 0;
        if (popped) e = sb_q.pop_front();
        else e = '{redir: 1'b0, halt: 1'b0, err: 1'b0, pc: 32'h0, tag: "R9 idle"};
        got_pc = redir ? redir_pc : (halt ? halt_pc : 32'h0);
        if (popped || redir || halt || bad_num || dslot_clr) begin
          checks++;
          if (redir !== e.redir || halt !== e.halt || bad_num !== e.err ||
              dslot_clr !== e.redir || got_pc !== e.pc) begin
            errors++;
            $display("FAIL %s: got redir=%b halt=%b err=%b clr=%b pc=%h, expected redir=%b halt=%b err=%b clr=%b pc=%h",
                     e.tag, redir, halt, bad_num, dslot_clr, got_pc,
                     e.redir, e.halt, e.err, e.redir, e.pc);
          end
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got run still active, expected completion");
    finish_run();
  end

  task automatic idle();
    exc_valid = 1'b0; ret_valid = 1'b0; reg_we = 1'b0; reg_sel = 2'd3;
    @(negedge clk);
  endtask

  task automatic chk_regs(input string tag);
    checks++;
    if (sr !== m_sr || esr !== m_esr || epcr !== m_epcr) begin
      errors++;
      $display("FAIL %s: got sr=%h esr=%h epcr=%h, expected sr=%h esr=%h epcr=%h",
               tag, sr, esr, epcr, m_sr, m_esr, m_epcr);
    end
  endtask

  // exception request; optional colliding return and software write
  task automatic drive_exc(input logic [4:0] num, input logic [31:0] pc,
                           input logic ds, input logic with_ret,
                           input logic with_wr, input string tag);
    exp_t e;
    exc_valid = 1'b1; exc_num = num; exc_pc = pc; exc_dslot = ds;
    ret_valid = with_ret; reg_we = with_wr; reg_sel = 2'd2; reg_wdata = 32'hDEAD_BEEF;
    e = '{redir: 1'b0, halt: 1'b0, err: 1'b0, pc: 32'h0, tag: tag};
    case (num)
      5'd14: begin e.halt = 1'b1; e.pc = pc; end
      5'd1, 5'd2, 5'd6, 5'd7, 5'd11, 5'd12, 5'd13: begin
        e.redir = 1'b1;
        e.pc = {(m_sr[14] ? 4'hF : 4'h0), 28'h0} + 32'(num) * 32'd256;
        if (num == 5'd12 || num == 5'd13) m_epcr = ds ? pc : pc + 32'd4;
        else if (num != 5'd1) m_epcr = ds ? pc - 32'd4 : pc;
        m_esr = m_sr;
        m_sr[13] = ds;
      end
      default: e.err = 1'b1;
    endcase
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic drive_ret(input string tag);
    exc_valid = 1'b0; ret_valid = 1'b1;
    sb_q.push_back('{redir: 1'b1, halt: 1'b0, err: 1'b0, pc: m_epcr, tag: tag});
    m_sr = m_esr | 32'h0000_8000;
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    case (sel)
      2'd0: m_sr = d | 32'h0000_8000;
      2'd1: m_esr = d;
      2'd2: m_epcr = d;
      default: ;
    endcase
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 2'd3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_regs("R1 reset registers");
    checks++;
    if (redir || halt || bad_num || dslot_clr) begin
      errors++;
      $display("FAIL R1 outputs: got %b%b%b%b, expected 0000", redir, halt, bad_num, dslot_clr);
    end

    drive_exc(5'd12, 32'h0000_1000, 1'b0, 1'b0, 1'b0, "R2 syscall"); idle();
    chk_regs("R2 syscall saved pc");
    drive_exc(5'd13, 32'h0000_2000, 1'b1, 1'b0, 1'b0, "R2 fpe dslot"); idle();
    chk_regs("R2 R4 fpe dslot");
    drive_exc(5'd7, 32'h0000_3008, 1'b1, 1'b0, 1'b0, "R3 illegal dslot"); idle();
    chk_regs("R3 illegal dslot");
    drive_exc(5'd2, 32'h0000_4000, 1'b0, 1'b0, 1'b0, "R3 bus error"); idle();
    chk_regs("R3 R4 bus error");
    drive_exc(5'd11, 32'h0000_5000, 1'b0, 1'b0, 1'b0, "R3 range"); idle();
    chk_regs("R3 range");

    sw_write(2'd0, 32'h0000_4000);
    chk_regs("R12 sr write forces bit 15");
    drive_exc(5'd6, 32'h0000_6000, 1'b1, 1'b0, 1'b0, "R5 prefixed align"); idle();
    chk_regs("R5 R3 prefixed align");
    drive_exc(5'd1, 32'h0000_7000, 1'b0, 1'b0, 1'b0, "R6 reset class"); idle();
    chk_regs("R6 saved pc kept");

    drive_exc(5'd14, 32'h0000_8000, 1'b0, 1'b0, 1'b0, "R7 trap"); idle();
    chk_regs("R7 trap keeps registers");

    sw_write(2'd1, 32'h0000_2001);
    sw_write(2'd2, 32'h0000_3000);
    chk_regs("R11 sw writes esr epcr");
    drive_ret("R8 return"); idle();
    chk_regs("R8 status restored");

    drive_exc(5'd3, 32'h0000_9000, 1'b0, 1'b0, 1'b0, "R10 bad number"); idle();
    chk_regs("R10 registers kept");
    drive_exc(5'd31, 32'h0000_9100, 1'b1, 1'b0, 1'b0, "R10 bad number 31"); idle();
    chk_regs("R10 registers kept 31");

    drive_exc(5'd12, 32'h0000_A000, 1'b0, 1'b1, 1'b1, "R11 collision"); idle();
    chk_regs("R11 exception wins");
    drive_exc(5'd14, 32'h0000_A100, 1'b0, 1'b1, 1'b1, "R11 trap with return"); idle();
    chk_regs("R11 return and write dropped");

    sw_write(2'd0, 32'h0000_0000);
    drive_exc(5'd13, 32'h0000_B000, 1'b0, 1'b0, 1'b0, "R9 back to back a");
    drive_exc(5'd7,  32'h0000_B004, 1'b1, 1'b0, 1'b0, "R9 back to back b");
    drive_ret("R9 back to back ret");
    idle(); idle();
    chk_regs("R9 back to back registers");

    sw_write(2'd3, 32'h1234_5678);
    chk_regs("R11 select 3 writes nothing");

    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R9 scoreboard drain: got %0d left, expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule